// File: doc/BRIEF.md
# PCI 64-bit Initiator Lane Steering

This block sequences the address and data phases of a PCI initiator whose bus is 64 bits wide. It takes one transaction request at a time: a 64-bit address, a bus command and a dword count. It drives AD[63:0] and C/BE[7:0], together with FRAME, IRDY and the 64-bit request line. When the target acknowledges 64-bit operation, each data phase moves two dwords. When it does not, the block drops to 32-bit phases and moves the upper write dword onto the low lanes. Addresses at or above 4 GB get a dual address cycle.

Write data comes from a queue outside the block. The block sees the two dwords at the head of that queue as a window, with their byte enables. On each completed data phase it reports how many dwords it consumed, so that the queue can pop them. All bus signals are modelled active-high. Arbitration, retries, terminations and read-data capture belong to other blocks. A dword count of zero is treated as one.

Top module: `p64_lane_steer`

## Requirements
- R1: While reset is asserted and after it is released, frame_o, irdy_o, req64_o and req64_oe are 0, deq_o is 0 and ready_o is 1. An asynchronous reset in the middle of a transaction returns the block to this state at once.
- R2: An address with bits [63:32] all zero gets one address phase. In that phase AD[31:0] carries the address, C/BE[3:0] carries the command, and AD[63:32] and C/BE[7:4] are driven 0.
- R3: An address with any of bits [63:32] set gets two address phases. The first carries the low address on AD[31:0] and the code 4'b1101 on C/BE[3:0]. The second carries the upper address on AD[31:0] and the command on C/BE[3:0]. In both phases AD[63:32] holds the upper address and C/BE[7:4] holds the command.
- R4: The 64-bit request is asserted only for memory write (0111), memory write and invalidate (1111), memory read multiple (1100) and memory read line (1110). When asserted, it is active in exactly the cycles in which frame_o is active.
- R5: In the first data phase, irdy_o stays low until DEVSEL has been sampled. It rises in the cycle after the first sampled DEVSEL. The width of the transfer is decided on that same edge: 64-bit only if the request was 64-bit and ACK64 was high.
- R6: In a 64-bit write, the head dword and its byte enables go on AD[31:0] and C/BE[3:0], and the next dword and its byte enables go on AD[63:32] and C/BE[7:4]. A completed phase reports deq_o = 2.
- R7: When ACK64 is absent at DEVSEL, every write phase is 32-bit. The head dword goes on the low lanes, AD[63:32] is 0, C/BE[7:4] is 4'hF and deq_o is 1, so the second dword appears on the low lanes in the second data phase.
- R8: In a 64-bit write whose final phase holds a single dword, C/BE[7:4] is 4'hF and AD[63:32] is 0 in that phase.
- R9: In reads, deq_o stays 0. For a 64-bit-requested read, C/BE[7:0] is 8'h00 in every data phase. For any other read it is 8'hF0, and AD is 0.
- R10: A data phase advances only on a clock where irdy_o and tgt_trdy are both high. In a wait state, deq_o is 0 and the lanes hold their values.
- R11: frame_o and the 64-bit request fall together in the final data phase, while irdy_o is high.
- R12: After the final transfer there is one cycle in which req64_oe is 1, req64_o is 0 and frame_o and irdy_o are 0. In the cycle after that, req64_oe is 0 and ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a transaction; taken only while ready_o is 1 |
| req_addr | input | 64 | Transaction address |
| req_cmd | input | 4 | Bus command |
| req_ndw | input | LEN_W | Number of dwords to transfer |
| hd0_data | input | 32 | Write dword at the queue head |
| hd0_be | input | 4 | Byte enables of the head dword |
| hd1_data | input | 32 | Write dword behind the head |
| hd1_be | input | 4 | Byte enables of the second dword |
| tgt_devsel | input | 1 | Target claims the transaction |
| tgt_ack64 | input | 1 | Target accepts 64-bit transfers |
| tgt_trdy | input | 1 | Target ready |
| ready_o | output | 1 | Block idle, request accepted |
| frame_o | output | 1 | FRAME |
| irdy_o | output | 1 | IRDY |
| req64_o | output | 1 | 64-bit request, timed with FRAME |
| req64_oe | output | 1 | Output enable of the 64-bit request line |
| ad_o | output | 64 | Address/data lanes |
| cbe_o | output | 8 | Command/byte-enable lanes |
| deq_o | output | 2 | Dwords consumed from the write queue this clock |

## Verification
The hardest case to reach is a multi-dword write in which the target claims the transaction late, without ACK64, and then adds a wait state. In that case the upper dword must move from the high lanes before DEVSEL to the low lanes in the second phase, and no dword may be lost or consumed twice. The stimulus table holds DEVSEL back for a set number of cycles, withholds ACK64 and inserts a TRDY wait state. A model of the queue in the bench pops on each reported deq_o and predicts the lanes of every phase. Other rows drive odd dword counts and addresses above 4 GB.

// File: rtl/p64_pkg.sv
`timescale 1ns/1ps
package p64_pkg;
    localparam int LANE_W = 32;
    localparam int BE_W   = 4;
    localparam int CMD_W  = 4;

    localparam logic [CMD_W-1:0] CMD_MEM_WR     = 4'h7;
    localparam logic [CMD_W-1:0] CMD_MEM_WR_INV = 4'hF;
    localparam logic [CMD_W-1:0] CMD_RD_MULT    = 4'hC;
    localparam logic [CMD_W-1:0] CMD_RD_LINE    = 4'hE;
    localparam logic [CMD_W-1:0] CMD_DUAL       = 4'hD;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADR1,
        PH_ADR2,
        PH_DATA,
        PH_TURN
    } phase_e;
endpackage

// File: rtl/p64_cmd_class.sv
`timescale 1ns/1ps
module p64_cmd_class
    import p64_pkg::*;
(
    input  logic [CMD_W-1:0]  cmd,
    input  logic [LANE_W-1:0] addr_hi,
    output logic              is_wr,
    output logic              want64,
    output logic              dual,
    output logic [CMD_W-1:0]  lead_cmd
);
    always_comb begin
        is_wr    = (cmd == CMD_MEM_WR) || (cmd == CMD_MEM_WR_INV);
        want64   = is_wr || (cmd == CMD_RD_MULT) || (cmd == CMD_RD_LINE);
        dual     = |addr_hi;
        lead_cmd = dual ? CMD_DUAL : cmd;
    end
endmodule

// File: rtl/p64_seq.sv
`timescale 1ns/1ps
module p64_seq
    import p64_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2*LANE_W-1:0] start_addr,
    input  logic [CMD_W-1:0]    start_cmd,
    input  logic [LEN_W-1:0]    start_ndw,
    input  logic                is_wr,
    input  logic                want64,
    input  logic                dual,
    input  logic                tgt_devsel,
    input  logic                tgt_ack64,
    input  logic                tgt_trdy,
    output phase_e              phase,
    output logic [2*LANE_W-1:0] addr_q,
    output logic [CMD_W-1:0]    cmd_q,
    output logic                wide_view,
    output logic                two_left,
    output logic                frame,
    output logic                irdy,
    output logic                req64,
    output logic                req64_oe,
    output logic [1:0]          deq,
    output logic                ready
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    typedef struct packed {
        phase_e              phase;
        logic [2*LANE_W-1:0] addr;
        logic [CMD_W-1:0]    cmd;
        logic [LEN_W-1:0]    rem;
        logic                seen;
        logic                wide;
    } seq_t;

    localparam seq_t SEQ_RST = '{phase: PH_IDLE, addr: '0, cmd: '0, rem: '0,
                                 seen: 1'b0, wide: 1'b0};

    seq_t s_d, s_q;
    logic last_ph;
    logic pair;

    always_comb begin
        s_d      = s_q;
        frame    = 1'b0;
        irdy     = 1'b0;
        req64_oe = 1'b0;
        deq      = 2'd0;
        ready    = 1'b0;
        pair     = s_q.wide && (s_q.rem >= TWO);
        last_ph  = s_q.wide ? (s_q.rem <= TWO) : (s_q.rem == ONE);
        unique case (s_q.phase)
            PH_IDLE: begin
                ready = 1'b1;
                if (start) begin
                    s_d.phase = PH_ADR1;
                    s_d.addr  = start_addr;
                    s_d.cmd   = start_cmd;
                    s_d.rem   = (start_ndw == '0) ? ONE : start_ndw;
                    s_d.seen  = 1'b0;
                    s_d.wide  = 1'b0;
                end
            end
            PH_ADR1: begin
                frame     = 1'b1;
                req64_oe  = 1'b1;
                s_d.phase = dual ? PH_ADR2 : PH_DATA;
            end
            PH_ADR2: begin
                frame     = 1'b1;
                req64_oe  = 1'b1;
                s_d.phase = PH_DATA;
            end
            PH_DATA: begin
                req64_oe = 1'b1;
                if (!s_q.seen) begin
                    frame = 1'b1;
                    if (tgt_devsel) begin
                        s_d.seen = 1'b1;
                        s_d.wide = want64 && tgt_ack64;
                    end
                end else begin
                    irdy  = 1'b1;
                    frame = !last_ph;
                    if (tgt_trdy) begin
                        s_d.rem = s_q.rem - (pair ? TWO : ONE);
                        deq     = is_wr ? (pair ? 2'd2 : 2'd1) : 2'd0;
                        if (last_ph) begin
                            s_d.phase = PH_TURN;
                        end
                    end
                end
            end
            PH_TURN: begin
                req64_oe  = 1'b1;
                s_d.phase = PH_IDLE;
            end
            default: s_d = SEQ_RST;
        endcase
        req64 = frame && want64;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase     = s_q.phase;
    assign addr_q    = s_q.addr;
    assign cmd_q     = s_q.cmd;
    assign wide_view = want64 && (!s_q.seen || s_q.wide);
    assign two_left  = s_q.rem >= TWO;
endmodule

// File: rtl/p64_lane_mux.sv
`timescale 1ns/1ps
module p64_lane_mux
    import p64_pkg::*;
(
    input  phase_e              phase,
    input  logic [2*LANE_W-1:0] addr,
    input  logic [CMD_W-1:0]    cmd,
    input  logic [CMD_W-1:0]    lead_cmd,
    input  logic                is_wr,
    input  logic                want64,
    input  logic                dual,
    input  logic                wide_view,
    input  logic                two_left,
    input  logic [LANE_W-1:0]   hd0_data,
    input  logic [BE_W-1:0]     hd0_be,
    input  logic [LANE_W-1:0]   hd1_data,
    input  logic [BE_W-1:0]     hd1_be,
    output logic [2*LANE_W-1:0] ad,
    output logic [2*BE_W-1:0]   cbe
);
    logic [LANE_W-1:0] a_lo, a_hi;
    assign a_lo = addr[LANE_W-1:0];
    assign a_hi = addr[2*LANE_W-1:LANE_W];

    always_comb begin
        ad  = '0;
        cbe = '0;
        unique case (phase)
            PH_ADR1: begin
                ad  = {dual ? a_hi : '0, a_lo};
                cbe = {dual ? cmd : '0, lead_cmd};
            end
            PH_ADR2: begin
                ad  = {a_hi, a_hi};
                cbe = {cmd, cmd};
            end
            PH_DATA: begin
                if (is_wr) begin
                    if (wide_view && two_left) begin
                        ad  = {hd1_data, hd0_data};
                        cbe = {hd1_be, hd0_be};
                    end else begin
                        ad  = {{LANE_W{1'b0}}, hd0_data};
                        cbe = {{BE_W{1'b1}}, hd0_be};
                    end
                end else begin
                    cbe = want64 ? '0 : {{BE_W{1'b1}}, {BE_W{1'b0}}};
                end
            end
            default: begin
                ad  = '0;
                cbe = '0;
            end
        endcase
    end
endmodule

// File: rtl/p64_lane_steer.sv
`timescale 1ns/1ps
module p64_lane_steer
    import p64_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [63:0]         req_addr,
    input  logic [3:0]          req_cmd,
    input  logic [LEN_W-1:0]    req_ndw,
    input  logic [31:0]         hd0_data,
    input  logic [3:0]          hd0_be,
    input  logic [31:0]         hd1_data,
    input  logic [3:0]          hd1_be,
    input  logic                tgt_devsel,
    input  logic                tgt_ack64,
    input  logic                tgt_trdy,
    output logic                ready_o,
    output logic                frame_o,
    output logic                irdy_o,
    output logic                req64_o,
    output logic                req64_oe,
    output logic [63:0]         ad_o,
    output logic [7:0]          cbe_o,
    output logic [1:0]          deq_o
);
    phase_e              phase;
    logic [2*LANE_W-1:0] addr_q;
    logic [CMD_W-1:0]    cmd_q;
    logic [CMD_W-1:0]    lead_cmd;
    logic                is_wr, want64, dual, wide_view, two_left;

    p64_cmd_class u_class (
        .cmd      (cmd_q),
        .addr_hi  (addr_q[2*LANE_W-1:LANE_W]),
        .is_wr    (is_wr),
        .want64   (want64),
        .dual     (dual),
        .lead_cmd (lead_cmd)
    );

    p64_seq #(.LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (req_valid),
        .start_addr (req_addr),
        .start_cmd  (req_cmd),
        .start_ndw  (req_ndw),
        .is_wr      (is_wr),
        .want64     (want64),
        .dual       (dual),
        .tgt_devsel (tgt_devsel),
        .tgt_ack64  (tgt_ack64),
        .tgt_trdy   (tgt_trdy),
        .phase      (phase),
        .addr_q     (addr_q),
        .cmd_q      (cmd_q),
        .wide_view  (wide_view),
        .two_left   (two_left),
        .frame      (frame_o),
        .irdy       (irdy_o),
        .req64      (req64_o),
        .req64_oe   (req64_oe),
        .deq        (deq_o),
        .ready      (ready_o)
    );

    p64_lane_mux u_mux (
        .phase     (phase),
        .addr      (addr_q),
        .cmd       (cmd_q),
        .lead_cmd  (lead_cmd),
        .is_wr     (is_wr),
        .want64    (want64),
        .dual      (dual),
        .wide_view (wide_view),
        .two_left  (two_left),
        .hd0_data  (hd0_data),
        .hd0_be    (hd0_be),
        .hd1_data  (hd1_data),
        .hd1_be    (hd1_be),
        .ad        (ad_o),
        .cbe       (cbe_o)
    );
endmodule

// File: rtl/p64_chk.sv
`timescale 1ns/1ps
module p64_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tgt_devsel,
    input logic       tgt_trdy,
    input logic       ready_o,
    input logic       frame_o,
    input logic       irdy_o,
    input logic       req64_o,
    input logic       req64_oe,
    input logic [1:0] deq_o
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!frame_o && !irdy_o && !req64_o && deq_o == 2'd0));

    // R4
    req64_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req64_o |-> frame_o);

    // R5
    irdy_after_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irdy_o) |-> $past(tgt_devsel));

    // R6
    deq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deq_o != 2'd3);

    // R10
    deq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_o != 2'd0) |-> (irdy_o && tgt_trdy));

    // R11
    frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_o) |-> (irdy_o && !req64_o));

    // R12
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req64_oe && !frame_o && !irdy_o) |=> !req64_oe);
endmodule

bind p64_lane_steer p64_chk u_chk (.*);

// File: tb/p64_lane_steer_test.sv
`timescale 1ns/1ps
module p64_lane_steer_test;
    localparam int LEN_W = 8;
    localparam int NCASE = 8;

    localparam logic [63:0] T_ADDR [0:NCASE-1] = '{
        64'h0000_0000_1000_0000, 64'h0000_0000_2000_0010,
        64'h0000_0001_2345_6780, 64'h0000_0000_0000_1000,
        64'hABCD_0000_0000_0040, 64'h0000_0000_0000_0200,
        64'h0000_0000_3000_0000, 64'h0000_0000_0000_0300};
    localparam logic [3:0] T_CMD  [0:NCASE-1] = '{4'h7, 4'h7, 4'h7, 4'hC, 4'hE, 4'h6, 4'hF, 4'h2};
    localparam int         T_NDW  [0:NCASE-1] = '{4, 3, 4, 4, 3, 2, 1, 1};
    localparam logic       T_ACK  [0:NCASE-1] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam int         T_DLY  [0:NCASE-1] = '{0, 1, 2, 0, 1, 0, 3, 0};
    localparam logic       T_WAIT [0:NCASE-1] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [3:0] req_cmd = '0;
    logic [LEN_W-1:0] req_ndw = '0;
    logic [31:0] hd0_data, hd1_data;
    logic [3:0] hd0_be, hd1_be;
    logic tgt_devsel = 1'b0, tgt_ack64 = 1'b0, tgt_trdy = 1'b0;
    logic ready_o, frame_o, irdy_o, req64_o, req64_oe;
    logic [63:0] ad_o;
    logic [7:0] cbe_o;
    logic [1:0] deq_o;

    logic [31:0] qd [0:15];
    logic [3:0] qbe [0:15];
    logic [3:0] ptr = '0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign hd0_data = qd[ptr];
    assign hd0_be   = qbe[ptr];
    assign hd1_data = qd[ptr + 4'd1];
    assign hd1_be   = qbe[ptr + 4'd1];

    p64_lane_steer #(.LEN_W(LEN_W)) uut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R6 R7 R8 R9: expected data-phase lanes from the bench queue
    task automatic chk_lanes(input string tag, input logic wr, input logic r64,
                             input logic wv, input int rem);
        logic [63:0] e_ad;
        logic [7:0] e_cbe;
        if (wr) begin
            if (wv && rem >= 2) begin
                e_ad  = {qd[ptr + 4'd1], qd[ptr]};
                e_cbe = {qbe[ptr + 4'd1], qbe[ptr]};
            end else begin
                e_ad  = {32'h0, qd[ptr]};
                e_cbe = {4'hF, qbe[ptr]};
            end
        end else begin
            e_ad  = '0;
            e_cbe = r64 ? 8'h00 : 8'hF0;
        end
        chk({tag, " ad"}, ad_o, e_ad);
        chk({tag, " cbe"}, {56'h0, cbe_o}, {56'h0, e_cbe});
    endtask

    task automatic run_txn(input logic [63:0] a, input logic [3:0] c, input int n,
                           input logic ack, input int dly, input logic wt);
        logic wr, r64, dual, wide, first, last;
        int rem, step;
        wr   = (c == 4'h7) || (c == 4'hF);
        r64  = wr || (c == 4'hC) || (c == 4'hE);
        dual = (a[63:32] != 32'h0);
        wide = r64 && ack;
        rem  = n;
        ptr  = '0;
        @(negedge clk);
        chk("R1 ready before request", {63'h0, ready_o}, 64'h1);
        req_valid = 1'b1; req_addr = a; req_cmd = c; req_ndw = LEN_W'(n);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R4 req64 in address phase", {63'h0, req64_o}, {63'h0, r64});
        chk("R2 frame in address phase", {63'h0, frame_o}, 64'h1);
        if (dual) begin
            chk("R3 first address ad", ad_o, a);
            chk("R3 first address cbe", {56'h0, cbe_o}, {56'h0, c, 4'hD});
            @(negedge clk); #1;
            chk("R3 second address ad", ad_o, {a[63:32], a[63:32]});
            chk("R3 second address cbe", {56'h0, cbe_o}, {56'h0, c, c});
            chk("R4 req64 in second address", {63'h0, req64_o}, {63'h0, r64});
        end else begin
            chk("R2 single address ad", ad_o, {32'h0, a[31:0]});
            chk("R2 single address cbe", {56'h0, cbe_o}, {56'h0, 4'h0, c});
        end
        for (int k = 0; k < dly; k++) begin
            @(negedge clk); #1;
            chk("R5 irdy low before devsel", {63'h0, irdy_o}, 64'h0);
            chk("R5 frame held before devsel", {63'h0, frame_o}, 64'h1);
            chk_lanes("R6 lanes before devsel", wr, r64, r64, rem);
        end
        @(negedge clk);
        tgt_devsel = 1'b1; tgt_ack64 = ack;
        #1;
        chk("R5 irdy low on devsel cycle", {63'h0, irdy_o}, 64'h0);
        first = 1'b1;
        while (rem > 0) begin
            @(negedge clk);
            if (wt && first) begin
                tgt_trdy = 1'b0;
                #1;
                chk("R10 irdy in wait state", {63'h0, irdy_o}, 64'h1);
                chk("R10 no dequeue in wait", {62'h0, deq_o}, 64'h0);
                chk_lanes("R10 lanes in wait", wr, r64, wide, rem);
                @(negedge clk);
            end
            first = 1'b0;
            tgt_trdy = 1'b1;
            #1;
            step = (wide && rem >= 2) ? 2 : 1;
            last = (rem == step);
            chk("R5 irdy in data phase", {63'h0, irdy_o}, 64'h1);
            chk("R11 frame in data phase", {63'h0, frame_o}, {63'h0, !last});
            chk("R11 req64 in data phase", {63'h0, req64_o}, {63'h0, !last && r64});
            chk_lanes(wide ? "R6 R8 wide lanes" : "R7 R9 narrow lanes", wr, r64, wide, rem);
            chk(wr ? "R6 R7 dequeue count" : "R9 no dequeue on read",
                {62'h0, deq_o}, wr ? 64'(step) : 64'h0);
            rem = rem - step;
            @(posedge clk); #1;
            if (wr) ptr = ptr + 4'(step);
        end
        @(negedge clk);
        tgt_trdy = 1'b0; tgt_devsel = 1'b0; tgt_ack64 = 1'b0;
        #1;
        chk("R12 frame low after last", {63'h0, frame_o}, 64'h0);
        chk("R12 irdy low after last", {63'h0, irdy_o}, 64'h0);
        chk("R12 req64 driven low", {63'h0, req64_o}, 64'h0);
        chk("R12 req64 still driven", {63'h0, req64_oe}, 64'h1);
        @(negedge clk); #1;
        chk("R12 req64 released", {63'h0, req64_oe}, 64'h0);
        chk("R12 ready again", {63'h0, ready_o}, 64'h1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            qd[i]  = 32'hC0DE_0000 + 32'(i * 32'h0011);
            qbe[i] = 4'(i) ^ 4'h3;
        end
        repeat (3) @(negedge clk);
        #1;
        chk("R1 frame in reset", {63'h0, frame_o}, 64'h0);
        chk("R1 req64_oe in reset", {63'h0, req64_oe}, 64'h0);
        chk("R1 ready in reset", {63'h0, ready_o}, 64'h1);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 irdy after reset", {63'h0, irdy_o}, 64'h0);
        chk("R1 deq after reset", {62'h0, deq_o}, 64'h0);

        for (int t = 0; t < NCASE; t++) begin
            run_txn(T_ADDR[t], T_CMD[t], T_NDW[t], T_ACK[t], T_DLY[t], T_WAIT[t]);
        end

        // R1: reset in the middle of a transaction
        @(negedge clk);
        req_valid = 1'b1; req_addr = 64'h0000_0000_4000_0000; req_cmd = 4'h7; req_ndw = 8'd4;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R1 frame before mid reset", {63'h0, frame_o}, 64'h1);
        rst_n = 1'b0;
        #1;
        chk("R1 frame after mid reset", {63'h0, frame_o}, 64'h0);
        chk("R1 req64 after mid reset", {63'h0, req64_o}, 64'h0);
        chk("R1 req64_oe after mid reset", {63'h0, req64_oe}, 64'h0);
        chk("R1 ready after mid reset", {63'h0, ready_o}, 64'h1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 idle after release", {63'h0, ready_o}, 64'h1);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule